// File: doc/BRIEF.md
# Mode-Switched Direct-Mapped Data Cache Controller

The block sits between a processor load/store port and a line-wide memory port. It holds a small direct-mapped data cache (16 lines of four 32-bit words by default). Each line has a valid bit, a tag, the line data and a clean-shared/modified flag. Two run-time mode bits set its allocation and write policy: cache-disable (`cd`) and no-write-through (`nw`).

With both bits clear the cache allocates on every miss. A modified victim is written back before the replacement line is fetched. Writes to shared lines are written through to memory, and a write-back-enable input decides whether such a write promotes the line to modified. With `cd` set (whatever `nw` is) the cache keeps serving and updating hits but never allocates, so misses go straight to memory. A mode write of `cd`=0, `nw`=1 is refused and raises a one-cycle fault with code zero. A global invalidate clears every line. It waits until no memory transaction is in flight, and it drops modified data without writing it back.

Top module: `mcache_ctrl`

## Requirements
- R1: After reset the mode reads `cd`=1, `nw`=0; `cpu_ready`, `mem_req` and `fault` are low and every line is invalid.
- R2: A mode write with `cd`=0, `nw`=1 leaves the mode unchanged and pulses `fault` high for exactly one cycle, one cycle after the write, with `fault_code` = 0. Every other combination is taken, and `fault` stays low.
- R3: In allocate mode (`cd`=0) a read miss fetches the line with one memory read and returns the requested word. Later reads of any word of that line complete with no memory traffic.
- R4: In allocate mode a miss whose victim is valid and modified first writes the whole victim line to memory (all four mask bits set) and only then reads the new line.
- R5: In allocate mode a write miss fills the line from memory, merges the word into the cache and writes it through to memory: one read and then one write.
- R6: A write hit to a shared line updates the cache and writes the word through to memory with a one-hot word mask (bit n = word offset n). A write hit to a modified line makes no memory transaction.
- R7: A write hit to a shared line promotes it to modified only when `wb_en` is high; with `wb_en` low it stays shared.
- R8: With `cd`=1 a read miss returns the word from one memory read without allocating: repeating the miss reads memory again, and the line already held at that index still hits.
- R9: With `cd`=1 a write hit updates the cached word (and writes through if shared), while a write miss makes exactly one memory write and allocates nothing.
- R10: The mode `cd`=1, `nw`=1 is accepted and behaves exactly as `cd`=1, `nw`=0.
- R11: A one-cycle `inval` pulse clears all valid bits without writing back modified lines. A pulse that arrives during a memory transaction takes effect once the controller is idle again.
- R12: `mem_req` stays high with a stable address until `mem_ack`, and `cpu_ready` is a single-cycle pulse that marks the end of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address: tag, index, word offset (low bits) |
| cpu_wdata | input | DW | Write data |
| wb_en | input | 1 | Allows a shared-line write hit to become modified |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mode_we | input | 1 | Mode write strobe |
| mode_cd | input | 1 | Cache-disable value to write |
| mode_nw | input | 1 | No-write-through value to write |
| mode_cd_q | output | 1 | Current cache-disable bit |
| mode_nw_q | output | 1 | Current no-write-through bit |
| fault | output | 1 | Illegal-mode fault pulse |
| fault_code | output | 8 | Fault code, zero |
| inval | input | 1 | Invalidate-all command |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | AW-log2(WORDS) | Line address |
| mem_wmask | output | WORDS | Per-word write enables |
| mem_wdata | output | WORDS*DW | Write line, word n at bits n*DW |
| mem_rdata | input | WORDS*DW | Read line, word n at bits n*DW |
| mem_ack | input | 1 | One-cycle completion of the memory request |

## Verification
The assertions assume a well-behaved neighbourhood. The processor holds `cpu_req` and its address, data and `wb_en` steady until `cpu_ready`. The memory raises `mem_ack` only while `mem_req` is high. Mode writes happen only between accesses, so a fill never starts under one policy and finishes under another. The bench drives each access from a task that keeps every processor input constant until it sees the ready pulse. Its memory model answers only an outstanding request after a fixed latency, and mode writes are issued only from the idle gaps between accesses.

// File: rtl/mcache_pkg.sv
package mcache_pkg;

    typedef struct packed {
        logic cd;
        logic nw;
    } mode_t;

    localparam mode_t      MODE_AT_RESET  = '{cd: 1'b1, nw: 1'b0};
    localparam logic [7:0] FAULT_BAD_MODE = 8'd0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WB,
        S_FILL,
        S_WT,
        S_BRD,
        S_BWR,
        S_RESP
    } seq_state_e;

    function automatic logic mode_illegal(mode_t m);
        return !m.cd && m.nw;
    endfunction

    function automatic logic mode_allocates(mode_t m);
        return !m.cd;
    endfunction

endpackage

// File: rtl/mcache_mode.sv
module mcache_mode
    import mcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_val,
    output mode_t mode_q,
    output logic  fault_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_AT_RESET;
            fault_q <= 1'b0;
        end else begin
            fault_q <= wr_en && mode_illegal(wr_val);
            if (wr_en && !mode_illegal(wr_val)) begin
                mode_q <= wr_val;
            end
        end
    end

    assert_illegal_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_illegal(wr_val)) |=> (fault_q && (mode_q == $past(mode_q))));

    assert_fault_single_R2: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !$past(wr_en)) |-> 1'b0);

endmodule

// File: rtl/mcache_store.sv
module mcache_store #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int TW    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(LINES)-1:0] idx,
    output logic                     line_valid,
    output logic                     line_mod,
    output logic [TW-1:0]            line_tag,
    output logic [WORDS*DW-1:0]      line_data,
    input  logic                     fill_en,
    input  logic [TW-1:0]            fill_tag,
    input  logic [WORDS*DW-1:0]      fill_data,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DW-1:0]            wr_data,
    input  logic                     wr_set_mod,
    input  logic                     inval_all
);

    localparam int LW = WORDS * DW;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] mod_q;
    logic [TW-1:0]    tag_q  [LINES];
    logic [LW-1:0]    data_q [LINES];

    assign line_valid = valid_q[idx];
    assign line_mod   = mod_q[idx];
    assign line_tag   = tag_q[idx];
    assign line_data  = data_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            mod_q   <= '0;
        end else if (inval_all) begin
            valid_q <= '0;
            mod_q   <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            mod_q[idx]   <= 1'b0;
        end else if (wr_en) begin
            mod_q[idx] <= mod_q[idx] | wr_set_mod;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= fill_tag;
            data_q[idx] <= fill_data;
        end else if (wr_en) begin
            data_q[idx][int'(wr_word)*DW +: DW] <= wr_data;
        end
    end

    assert_inval_clears_R11: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (valid_q == '0));

    assert_fill_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !inval_all) |=> (valid_q[$past(idx)] && !mod_q[$past(idx)]));

endmodule

// File: rtl/mcache_seq.sv
module mcache_seq
    import mcache_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    parameter int LINES = 16
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         cpu_req,
    input  logic                                         cpu_we,
    input  logic [AW-1:0]                                cpu_addr,
    input  logic [DW-1:0]                                cpu_wdata,
    input  logic                                         wb_en,
    input  logic                                         allocate,
    input  logic                                         inval,
    output logic [DW-1:0]                                cpu_rdata,
    output logic                                         cpu_ready,
    output logic                                         mem_req,
    output logic                                         mem_we,
    output logic [AW-$clog2(WORDS)-1:0]                  mem_addr,
    output logic [WORDS-1:0]                             mem_wmask,
    output logic [WORDS*DW-1:0]                          mem_wdata,
    input  logic [WORDS*DW-1:0]                          mem_rdata,
    input  logic                                         mem_ack,
    output logic [$clog2(LINES)-1:0]                     st_idx,
    input  logic                                         st_valid,
    input  logic                                         st_mod,
    input  logic [AW-$clog2(WORDS)-$clog2(LINES)-1:0]    st_tag,
    input  logic [WORDS*DW-1:0]                          st_line,
    output logic                                         st_fill,
    output logic                                         st_wr,
    output logic                                         st_set_mod,
    output logic                                         st_inval,
    output logic [AW-$clog2(WORDS)-$clog2(LINES)-1:0]    req_tag,
    output logic [$clog2(WORDS)-1:0]                     req_off
);

    localparam int OB = $clog2(WORDS);
    localparam int IB = $clog2(LINES);
    localparam int TW = AW - OB - IB;

    seq_state_e       state_q, state_d;
    logic             inval_pend_q;
    logic             inval_now;
    logic             hit;
    logic             lookup;
    logic [WORDS-1:0] word_sel;
    logic [DW-1:0]    rdata_q;

    assign req_off = cpu_addr[OB-1:0];
    assign st_idx  = cpu_addr[OB +: IB];
    assign req_tag = cpu_addr[AW-1 -: TW];
    assign hit     = st_valid && (st_tag == req_tag);

    assign inval_now  = (state_q == S_IDLE) && (inval_pend_q || inval);
    assign lookup     = (state_q == S_IDLE) && !inval_now && cpu_req;
    assign st_inval   = inval_now;
    assign st_wr      = lookup && cpu_we && hit;
    assign st_set_mod = wb_en;
    assign st_fill    = (state_q == S_FILL) && mem_ack;

    for (genvar w = 0; w < WORDS; w++) begin : g_wsel
        assign word_sel[w] = (req_off == OB'(w));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (lookup) begin
                    if (hit)           state_d = (cpu_we && !st_mod) ? S_WT : S_RESP;
                    else if (!allocate) state_d = cpu_we ? S_BWR : S_BRD;
                    else               state_d = (st_valid && st_mod) ? S_WB : S_FILL;
                end
            end
            S_WB:   if (mem_ack) state_d = S_FILL;
            S_FILL: if (mem_ack) state_d = S_IDLE;
            S_WT, S_BRD, S_BWR: if (mem_ack) state_d = S_RESP;
            S_RESP: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            inval_pend_q <= 1'b0;
            rdata_q      <= '0;
        end else begin
            state_q      <= state_d;
            inval_pend_q <= (inval_pend_q || inval) && !inval_now;
            if (lookup && !cpu_we && hit) begin
                rdata_q <= st_line[int'(req_off)*DW +: DW];
            end else if ((state_q == S_BRD) && mem_ack) begin
                rdata_q <= mem_rdata[int'(req_off)*DW +: DW];
            end
        end
    end

    assign cpu_ready = (state_q == S_RESP);
    assign cpu_rdata = rdata_q;

    assign mem_req   = (state_q == S_WB) || (state_q == S_FILL) || (state_q == S_WT) ||
                       (state_q == S_BRD) || (state_q == S_BWR);
    assign mem_we    = (state_q == S_WB) || (state_q == S_WT) || (state_q == S_BWR);
    assign mem_addr  = (state_q == S_WB) ? {st_tag, st_idx} : cpu_addr[AW-1:OB];
    assign mem_wmask = (state_q == S_WB) ? '1 : word_sel;
    assign mem_wdata = (state_q == S_WB) ? st_line : {WORDS{cpu_wdata}};

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_wb_then_fill_R4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == S_WB) && mem_ack) |=> ((state_q == S_FILL) && mem_req && !mem_we));

    assert_no_alloc_R8: assert property (@(posedge clk) disable iff (rst)
        st_fill |-> allocate);

    assert_inval_idle_R11: assert property (@(posedge clk) disable iff (rst)
        st_inval |-> !mem_req);

endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
    import mcache_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int WORDS = 4,
    parameter int LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [AW-1:0]               cpu_addr,
    input  logic [DW-1:0]               cpu_wdata,
    input  logic                        wb_en,
    output logic [DW-1:0]               cpu_rdata,
    output logic                        cpu_ready,
    input  logic                        mode_we,
    input  logic                        mode_cd,
    input  logic                        mode_nw,
    output logic                        mode_cd_q,
    output logic                        mode_nw_q,
    output logic                        fault,
    output logic [7:0]                  fault_code,
    input  logic                        inval,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [AW-$clog2(WORDS)-1:0] mem_addr,
    output logic [WORDS-1:0]            mem_wmask,
    output logic [WORDS*DW-1:0]         mem_wdata,
    input  logic [WORDS*DW-1:0]         mem_rdata,
    input  logic                        mem_ack
);

    localparam int OB = $clog2(WORDS);
    localparam int IB = $clog2(LINES);
    localparam int TW = AW - OB - IB;
    localparam int LW = WORDS * DW;

    mode_t           wr_mode, cur_mode;
    logic [IB-1:0]   st_idx;
    logic            st_valid, st_mod, st_fill, st_wr, st_set_mod, st_inval;
    logic [TW-1:0]   st_tag, req_tag;
    logic [LW-1:0]   st_line;
    logic [OB-1:0]   req_off;

    assign wr_mode    = '{cd: mode_cd, nw: mode_nw};
    assign mode_cd_q  = cur_mode.cd;
    assign mode_nw_q  = cur_mode.nw;
    assign fault_code = FAULT_BAD_MODE;

    mcache_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_we),
        .wr_val  (wr_mode),
        .mode_q  (cur_mode),
        .fault_q (fault)
    );

    mcache_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW), .TW(TW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .idx        (st_idx),
        .line_valid (st_valid),
        .line_mod   (st_mod),
        .line_tag   (st_tag),
        .line_data  (st_line),
        .fill_en    (st_fill),
        .fill_tag   (req_tag),
        .fill_data  (mem_rdata),
        .wr_en      (st_wr),
        .wr_word    (req_off),
        .wr_data    (cpu_wdata),
        .wr_set_mod (st_set_mod),
        .inval_all  (st_inval)
    );

    mcache_seq #(.AW(AW), .DW(DW), .WORDS(WORDS), .LINES(LINES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .wb_en      (wb_en),
        .allocate   (mode_allocates(cur_mode)),
        .inval      (inval),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wmask  (mem_wmask),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .st_idx     (st_idx),
        .st_valid   (st_valid),
        .st_mod     (st_mod),
        .st_tag     (st_tag),
        .st_line    (st_line),
        .st_fill    (st_fill),
        .st_wr      (st_wr),
        .st_set_mod (st_set_mod),
        .st_inval   (st_inval),
        .req_tag    (req_tag),
        .req_off    (req_off)
    );

    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
        !(mode_illegal(cur_mode) && !$past(mode_illegal(cur_mode))));

endmodule

// File: tb/mcache_ctrl_tb.sv
module mcache_ctrl_tb;

    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 4;
    localparam int LINES = 16;
    localparam int LW    = WORDS * DW;
    localparam int LAW   = AW - 2;
    localparam int LAT   = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cpu_req = 1'b0, cpu_we = 1'b0, wb_en = 1'b0;
    logic [AW-1:0]  cpu_addr = '0;
    logic [DW-1:0]  cpu_wdata = '0;
    logic [DW-1:0]  cpu_rdata;
    logic           cpu_ready;
    logic           mode_we = 1'b0, mode_cd = 1'b0, mode_nw = 1'b0;
    logic           mode_cd_q, mode_nw_q, fault;
    logic [7:0]     fault_code;
    logic           inval = 1'b0;
    logic           mem_req, mem_we;
    logic [LAW-1:0] mem_addr;
    logic [WORDS-1:0] mem_wmask;
    logic [LW-1:0]  mem_wdata;
    logic [LW-1:0]  mem_rdata = '0;
    logic           mem_ack = 1'b0;

    mcache_ctrl #(.AW(AW), .DW(DW), .WORDS(WORDS), .LINES(LINES)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wb_en(wb_en), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mode_we(mode_we), .mode_cd(mode_cd), .mode_nw(mode_nw), .mode_cd_q(mode_cd_q),
        .mode_nw_q(mode_nw_q), .fault(fault), .fault_code(fault_code), .inval(inval),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mem [1 << AW];
    int nrd = 0, nwr = 0, first_kind = 0;
    logic [DW-1:0] res_d;
    int res_r, res_w, res_k;

    function automatic logic [DW-1:0] seed_val(int a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0001_0003);
    endfunction

    function automatic logic [AW-1:0] A(int t, int i, int o);
        return {4'(t), 4'(i), 2'(o)};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: fixed latency, one-cycle acknowledge
    initial begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < (1 << AW); i++) mem[i] = seed_val(i);
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt == LAT) begin
                    cnt = 0;
                    if (mem_we) begin
                        nwr++;
                        if (first_kind == 0) first_kind = 2;
                        for (int w = 0; w < WORDS; w++)
                            if (mem_wmask[w]) mem[int'(mem_addr) * WORDS + w] = mem_wdata[w*DW +: DW];
                    end else begin
                        nrd++;
                        if (first_kind == 0) first_kind = 1;
                        for (int w = 0; w < WORDS; w++)
                            mem_rdata[w*DW +: DW] = mem[int'(mem_addr) * WORDS + w];
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic wbe);
        int r0, w0, cyc;
        @(negedge clk);
        r0 = nrd; w0 = nwr; cyc = 0; first_kind = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; wb_en = wbe;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 1000);
        res_d = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0; wb_en = 1'b0;
        res_r = nrd - r0; res_w = nwr - w0; res_k = first_kind;
        @(negedge clk);
        chk("R12 ready single pulse", 32'(cpu_ready), 32'd0);
    endtask

    task automatic set_mode(input logic cd, input logic nw);
        @(negedge clk);
        mode_we = 1'b1; mode_cd = cd; mode_nw = nw;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cd", 32'(mode_cd_q), 32'd1);
        chk("R1 nw", 32'(mode_nw_q), 32'd0);
        chk("R1 ready", 32'(cpu_ready), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 fault", 32'(fault), 32'd0);

        // R2 illegal mode from reset mode
        set_mode(1'b0, 1'b1);
        chk("R2 fault pulse", 32'(fault), 32'd1);
        chk("R2 fault code", 32'(fault_code), 32'd0);
        chk("R2 cd kept", 32'(mode_cd_q), 32'd1);
        chk("R2 nw kept", 32'(mode_nw_q), 32'd0);
        @(negedge clk);
        chk("R2 fault one cycle", 32'(fault), 32'd0);
        set_mode(1'b0, 1'b0);
        chk("R2 legal cd", 32'(mode_cd_q), 32'd0);
        chk("R2 legal no fault", 32'(fault), 32'd0);
        set_mode(1'b0, 1'b1);
        chk("R2 fault again", 32'(fault), 32'd1);
        chk("R2 nw kept 0", 32'(mode_nw_q), 32'd0);

        // R3 read miss fills, then hits
        for (int i = 0; i < LINES; i++) begin
            access(1'b0, A(1, i, i % 4), '0, 1'b0);
            chk("R3 miss data", res_d, seed_val(int'(A(1, i, i % 4))));
            chk("R3 miss reads", 32'(res_r), 32'd1);
            access(1'b0, A(1, i, (i + 1) % 4), '0, 1'b0);
            chk("R3 hit data", res_d, seed_val(int'(A(1, i, (i + 1) % 4))));
            chk("R3 hit traffic", 32'(res_r + res_w), 32'd0);
        end

        // R6 write hit on shared line writes through, R7 stays shared without wb_en
        for (int i = 0; i < LINES; i++) begin
            access(1'b1, A(1, i, 0), 32'hC0DE_0000 + 32'(i), 1'b0);
            chk("R6 wt writes", 32'(res_w), 32'd1);
            chk("R6 wt no read", 32'(res_r), 32'd0);
            chk("R6 mem word", mem[int'(A(1, i, 0))], 32'hC0DE_0000 + 32'(i));
            chk("R6 other word untouched", mem[int'(A(1, i, 3))], seed_val(int'(A(1, i, 3))));
            access(1'b1, A(1, i, 0), 32'hC1DE_0000 + 32'(i), 1'b0);
            chk("R7 still shared writes", 32'(res_w), 32'd1);
            access(1'b0, A(1, i, 0), '0, 1'b0);
            chk("R6 readback", res_d, 32'hC1DE_0000 + 32'(i));
        end

        // R7 promotion with wb_en, R6 modified hit makes no traffic
        for (int i = 0; i < LINES; i++) begin
            access(1'b1, A(1, i, 1), 32'hBEEF_0000 + 32'(i), 1'b1);
            chk("R7 promote writes through", 32'(res_w), 32'd1);
            access(1'b1, A(1, i, 2), 32'hFACE_0000 + 32'(i), 1'b0);
            chk("R6 modified hit silent", 32'(res_w + res_r), 32'd0);
            chk("R7 mem stale", mem[int'(A(1, i, 2))], seed_val(int'(A(1, i, 2))));
        end

        // R4 dirty victim written back before fill
        for (int i = 0; i < LINES; i++) begin
            access(1'b0, A(2, i, 3), '0, 1'b0);
            chk("R4 data", res_d, seed_val(int'(A(2, i, 3))));
            chk("R4 one wb", 32'(res_w), 32'd1);
            chk("R4 one fill", 32'(res_r), 32'd1);
            chk("R4 wb first", 32'(res_k), 32'd2);
            chk("R4 victim in mem", mem[int'(A(1, i, 2))], 32'hFACE_0000 + 32'(i));
        end

        // R5 write miss fills then writes through
        for (int i = 0; i < LINES; i++) begin
            access(1'b1, A(3, i, 0), 32'h3333_0000 + 32'(i), 1'b0);
            chk("R5 reads", 32'(res_r), 32'd1);
            chk("R5 writes", 32'(res_w), 32'd1);
            chk("R5 read first", 32'(res_k), 32'd1);
            chk("R5 mem", mem[int'(A(3, i, 0))], 32'h3333_0000 + 32'(i));
            access(1'b0, A(3, i, 0), '0, 1'b0);
            chk("R5 allocated hit", 32'(res_r), 32'd0);
            chk("R5 readback", res_d, 32'h3333_0000 + 32'(i));
        end

        // R11 invalidate discards modified data
        access(1'b1, A(3, 7, 1), 32'hAAAA_0001, 1'b1);
        access(1'b1, A(3, 7, 1), 32'hAAAA_0002, 1'b0);
        chk("R11 modified silent", 32'(res_w), 32'd0);
        pulse_inval();
        access(1'b0, A(3, 7, 1), '0, 1'b0);
        chk("R11 refetch", 32'(res_r), 32'd1);
        chk("R11 no writeback", 32'(res_w), 32'd0);
        chk("R11 dropped data", res_d, 32'hAAAA_0001);
        access(1'b0, A(3, 8, 0), '0, 1'b0);
        chk("R11 other line cleared", 32'(res_r), 32'd1);
        chk("R11 other data", res_d, 32'h3333_0008);

        // R8 no-fill reads
        set_mode(1'b1, 1'b0);
        access(1'b0, A(3, 7, 2), '0, 1'b0);
        chk("R8 hit served", 32'(res_r), 32'd0);
        chk("R8 hit data", res_d, seed_val(int'(A(3, 7, 2))));
        for (int i = 0; i < LINES; i++) begin
            access(1'b0, A(4, i, 0), '0, 1'b0);
            chk("R8 miss reads", 32'(res_r), 32'd1);
            chk("R8 miss data", res_d, seed_val(int'(A(4, i, 0))));
            access(1'b0, A(4, i, 0), '0, 1'b0);
            chk("R8 not allocated", 32'(res_r), 32'd1);
        end
        access(1'b0, A(3, 7, 2), '0, 1'b0);
        chk("R8 occupant kept", 32'(res_r), 32'd0);

        // R9 no-fill writes
        access(1'b1, A(3, 7, 3), 32'h9999_0003, 1'b0);
        chk("R9 hit writes through", 32'(res_w), 32'd1);
        chk("R9 hit no read", 32'(res_r), 32'd0);
        access(1'b0, A(3, 7, 3), '0, 1'b0);
        chk("R9 hit updated cache", res_d, 32'h9999_0003);
        chk("R9 readback hit", 32'(res_r), 32'd0);
        access(1'b1, A(4, 7, 0), 32'h9999_0040, 1'b0);
        chk("R9 miss one write", 32'(res_w), 32'd1);
        chk("R9 miss no read", 32'(res_r), 32'd0);
        chk("R9 miss mem", mem[int'(A(4, 7, 0))], 32'h9999_0040);
        access(1'b0, A(4, 7, 0), '0, 1'b0);
        chk("R9 miss not allocated", 32'(res_r), 32'd1);
        chk("R9 miss data", res_d, 32'h9999_0040);

        // R10 cd=1 nw=1 acts as no-fill
        set_mode(1'b1, 1'b1);
        chk("R10 accepted nw", 32'(mode_nw_q), 32'd1);
        chk("R10 no fault", 32'(fault), 32'd0);
        access(1'b0, A(6, 8, 0), '0, 1'b0);
        chk("R10 miss reads", 32'(res_r), 32'd1);
        access(1'b0, A(6, 8, 0), '0, 1'b0);
        chk("R10 not allocated", 32'(res_r), 32'd1);
        access(1'b0, A(3, 8, 0), '0, 1'b0);
        chk("R10 occupant hit", 32'(res_r), 32'd0);
        chk("R10 occupant data", res_d, 32'h3333_0008);
        access(1'b1, A(6, 8, 1), 32'h6666_0001, 1'b0);
        chk("R10 write miss", 32'(res_w + res_r), 32'd1);
        chk("R10 write miss mem", mem[int'(A(6, 8, 1))], 32'h6666_0001);

        // R11 invalidate during a memory transaction is deferred, then applied
        fork
            access(1'b0, A(6, 9, 0), '0, 1'b0);
            begin
                repeat (2) @(negedge clk);
                inval = 1'b1;
                @(negedge clk);
                inval = 1'b0;
            end
        join
        chk("R11 bypass data", res_d, seed_val(int'(A(6, 9, 0))));
        access(1'b0, A(3, 8, 0), '0, 1'b0);
        chk("R11 deferred clear", 32'(res_r), 32'd1);

        // back to allocate mode: refill then hit
        set_mode(1'b0, 1'b0);
        access(1'b0, A(3, 8, 0), '0, 1'b0);
        chk("R3 refill", 32'(res_r), 32'd1);
        access(1'b0, A(3, 8, 0), '0, 1'b0);
        chk("R3 refill hit", 32'(res_r), 32'd0);
        chk("R3 refill data", res_d, 32'h3333_0008);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule